// File: doc/BRIEF.md
# SPI master shift engine

This block is a single-channel SPI master that moves one word per request in both directions at once. The host writes a small configuration (clock polarity, an edge-select bit, a word length and a baud divisor) while the engine is idle. It then presents a transmit word with a one-cycle start pulse. The engine generates the serial clock and drives the outgoing data line most significant bit first. For every bit it sends, it captures one bit from the incoming line into the same shift register. When the last clock edge has gone out, it returns the received word with a one-cycle valid pulse.

The edge-select bit is the inverse of the usual clock-phase bit. When it is 1, the engine samples on the transition from the idle level to the active level and changes its output on the opposite transition. When it is 0, the engine changes its output on the idle-to-active transition and samples on the return to idle. Chip select is a separate output that the host drives directly, so one transaction can span any number of words. A read-only transfer still shifts out a word, which may be don't-care data.

Top module: `spi_shift_master`

## Requirements
- R1: After reset the block is idle, with `busy` and `rxValid` low, `csN` high, `mosi` low and `sck` low. The configuration after reset is polarity 0, edge-select 1, word length 8 and divisor 0.
- R2: Each half period of `sck` during a word lasts `cfgDiv+1` clock cycles, which gives a bit rate of clk/(2*(cfgDiv+1)). The first `sck` transition comes `cfgDiv+1` cycles after the start is accepted, and `rxValid` rises 2*W*(`cfgDiv`+1) cycles after acceptance, where W is the word length.
- R3: While idle, `sck` rests at the level written to `cfgPol` (0 = low, 1 = high), and it returns to that level after the last edge of each word.
- R4: With `cfgEdge`=1, `miso` is sampled on every idle-to-active transition and `mosi` changes on active-to-idle transitions. With `cfgEdge`=0, `mosi` changes on idle-to-active transitions and `miso` is sampled on active-to-idle transitions. Outside these transitions, `mosi` holds steady during a word.
- R5: Bits go out most significant first. The first bit of the word is on `mosi` from the cycle after the start is accepted, before any `sck` transition. After the word ends, `mosi` holds the last bit sent.
- R6: `cfgWidth` selects the word length: 2'b00 is 8 bits, 2'b01 is 16 bits, and 2'b10 or 2'b11 is 32 bits. A word has exactly 2*W `sck` transitions, and the transmit data is taken from `txWord[W-1:0]`.
- R7: The received word is right-justified on `rxWord`. The first bit sampled lands in bit W-1, the last bit sampled lands in bit 0, and bits above W-1 read as zero.
- R8: `busy` is high from the cycle after an accepted start until the cycle in which the last `sck` transition is made. `rxValid` is high for exactly that one cycle, and `busy` is low in it.
- R9: While `busy` is high, a `start` pulse and a configuration write are ignored. The word in flight keeps its length, timing and data, and `sck` afterwards rests at the polarity in force before the write.
- R10: `csN` equals the inverse of `csEn` one clock later, independently of any transfer.
- R11: With `miso` tied to `mosi`, the received word equals the transmitted word in all four clock modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Configuration write strobe, accepted only while idle |
| cfgPol | input | 1 | Idle level of `sck` |
| cfgEdge | input | 1 | Edge select, inverse of clock phase |
| cfgWidth | input | 2 | Word length code (8/16/32) |
| cfgDiv | input | DIV_W | Baud divisor |
| start | input | 1 | Start pulse for one word |
| txWord | input | 32 | Word to transmit, right-justified |
| csEn | input | 1 | Host request to assert chip select |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| csN | output | 1 | Chip select, active low |
| busy | output | 1 | Word in progress |
| rxValid | output | 1 | One-cycle pulse with the received word |
| rxWord | output | 32 | Received word, right-justified |

## Verification
All four polarity and edge-select combinations are crossed with the three word lengths and with divisors from 0 to 3. Pseudo-random data on `miso` exposes any sampling on the wrong transition, or off by one edge, because such an error shifts or corrupts the received bits. A loopback run ties `miso` to `mosi`. It separates a correct phase relationship, where the word comes back unchanged, from an engine whose sample and change edges coincide. A disturbed transfer injects a start and a configuration write in mid-word, which shows whether either one leaks into the word in flight or into the idle clock level that follows.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;

  localparam int WORD_MAX = 32;
  localparam int CNT_W    = $clog2(2 * WORD_MAX);

  // strobes from control to datapath, at most one of sample/drive per cycle
  typedef struct packed {
    logic load;    // capture a new transmit word
    logic sample;  // shift in one bit from miso
    logic drive;   // present the next bit on mosi
  } shiftStrobe_t;

  function automatic logic [CNT_W:0] wordBits(input logic [1:0] sel);
    case (sel)
      2'b00:   wordBits = (CNT_W+1)'(8);
      2'b01:   wordBits = (CNT_W+1)'(16);
      default: wordBits = (CNT_W+1)'(WORD_MAX);
    endcase
  endfunction

endpackage

// File: rtl/spi_shift_ctrl.sv
module spi_shift_ctrl
  import spi_shift_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic             cfgPol,
  input  logic             cfgEdge,
  input  logic [1:0]       cfgWidth,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic             start,
  input  logic             csEn,
  output logic             sck,
  output logic             busy,
  output logic             rxValid,
  output logic             csN,
  output logic [1:0]       widthSel,
  output shiftStrobe_t     strb
);

  logic             polQ;
  logic             edgeQ;
  logic [1:0]       widthQ;
  logic [DIV_W-1:0] divQ;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] edgeCnt;
  logic             busyQ;
  logic             phaseQ;
  logic             validQ;
  logic             csNQ;

  logic [CNT_W:0]   lastIdx;
  logic             tick;
  logic             lastEdge;
  logic             cpha;
  logic             accept;
  logic             sampleNow;

  always_comb begin
    cpha      = ~edgeQ;
    accept    = start & ~busyQ;
    tick      = busyQ && (divCnt == divQ);
    lastIdx   = (wordBits(widthQ) << 1) - 1'b1;
    lastEdge  = ({1'b0, edgeCnt} == lastIdx);
    // even edges lead (idle->active), odd edges trail
    sampleNow = tick && (edgeCnt[0] == cpha);
    strb.load   = accept;
    strb.sample = sampleNow;
    strb.drive  = tick && !sampleNow && !lastEdge;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polQ    <= 1'b0;
      edgeQ   <= 1'b1;
      widthQ  <= 2'b00;
      divQ    <= '0;
      divCnt  <= '0;
      edgeCnt <= '0;
      busyQ   <= 1'b0;
      phaseQ  <= 1'b0;
      validQ  <= 1'b0;
      csNQ    <= 1'b1;
    end else begin
      validQ <= 1'b0;
      csNQ   <= ~csEn;
      if (!busyQ) begin
        if (cfgWe) begin
          polQ   <= cfgPol;
          edgeQ  <= cfgEdge;
          widthQ <= cfgWidth;
          divQ   <= cfgDiv;
        end
        if (accept) begin
          busyQ   <= 1'b1;
          divCnt  <= '0;
          edgeCnt <= '0;
        end
      end else if (tick) begin
        divCnt  <= '0;
        phaseQ  <= ~phaseQ;
        edgeCnt <= edgeCnt + 1'b1;
        if (lastEdge) begin
          busyQ  <= 1'b0;
          validQ <= 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign sck      = polQ ^ phaseQ;
  assign busy     = busyQ;
  assign rxValid  = validQ;
  assign csN      = csNQ;
  assign widthSel = widthQ;

endmodule

// File: rtl/spi_shift_dp.sv
module spi_shift_dp
  import spi_shift_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  shiftStrobe_t        strb,
  input  logic [1:0]          widthSel,
  input  logic [WORD_MAX-1:0] txWord,
  input  logic                miso,
  output logic                mosi,
  output logic [WORD_MAX-1:0] rxWord
);

  logic [WORD_MAX-1:0] shiftReg;
  logic [WORD_MAX-1:0] aligned;
  logic [WORD_MAX-1:0] keepMask;
  logic                mosiQ;

  always_comb begin
    case (widthSel)
      2'b00: begin
        aligned  = {txWord[7:0], {(WORD_MAX-8){1'b0}}};
        keepMask = WORD_MAX'(8'hFF);
      end
      2'b01: begin
        aligned  = {txWord[15:0], {(WORD_MAX-16){1'b0}}};
        keepMask = WORD_MAX'(16'hFFFF);
      end
      default: begin
        aligned  = txWord;
        keepMask = '1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      mosiQ    <= 1'b0;
    end else if (strb.load) begin
      shiftReg <= aligned;
      mosiQ    <= aligned[WORD_MAX-1];
    end else if (strb.sample) begin
      shiftReg <= {shiftReg[WORD_MAX-2:0], miso};
    end else if (strb.drive) begin
      mosiQ    <= shiftReg[WORD_MAX-1];
    end
  end

  assign mosi   = mosiQ;
  assign rxWord = shiftReg & keepMask;

endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master
  import spi_shift_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic                cfgPol,
  input  logic                cfgEdge,
  input  logic [1:0]          cfgWidth,
  input  logic [DIV_W-1:0]    cfgDiv,
  input  logic                start,
  input  logic [WORD_MAX-1:0] txWord,
  input  logic                csEn,
  input  logic                miso,
  output logic                sck,
  output logic                mosi,
  output logic                csN,
  output logic                busy,
  output logic                rxValid,
  output logic [WORD_MAX-1:0] rxWord
);

  shiftStrobe_t strb;
  logic [1:0]   widthSel;

  spi_shift_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgPol(cfgPol), .cfgEdge(cfgEdge),
    .cfgWidth(cfgWidth), .cfgDiv(cfgDiv), .start(start), .csEn(csEn),
    .sck(sck), .busy(busy), .rxValid(rxValid), .csN(csN),
    .widthSel(widthSel), .strb(strb)
  );

  spi_shift_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .widthSel(widthSel),
    .txWord(txWord), .miso(miso), .mosi(mosi), .rxWord(rxWord)
  );

endmodule

// File: rtl/spi_shift_master_chk.sv
module spi_shift_master_chk (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic csEn,
  input logic sck,
  input logic mosi,
  input logic csN,
  input logic busy,
  input logic rxValid
);

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid); // R8

  AST_VALID_ENDS_WORD: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> (!busy && $past(busy))); // R8

  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start)); // R9

  AST_FIRST_EDGE_LATER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $stable(sck)); // R2

  AST_MOSI_ON_EDGES: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && $stable(sck)) |-> $stable(mosi)); // R4

  AST_CS_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (csN == !$past(csEn))); // R10

endmodule

bind spi_shift_master spi_shift_master_chk u_chk (.*);

// File: tb/spi_shift_master_bench.sv
module spi_shift_master_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0, cfgPol = 1'b0, cfgEdge = 1'b1;
  logic [1:0]  cfgWidth = 2'b00;
  logic [7:0]  cfgDiv = 8'd0;
  logic        start = 1'b0;
  logic [31:0] txWord = '0;
  logic        csEn = 1'b0;
  logic        miso;
  logic        sck, mosi, csN, busy, rxValid;
  logic [31:0] rxWord;
  logic        loopMode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic        compareOn = 1'b0;
  logic        doneFlag = 1'b0;
  int          checks = 0;
  int          fails = 0;

  always #5 clk = ~clk;

  assign miso = loopMode ? mosi : lfsr[0];
  always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

  spi_shift_master u_spi_shift_master (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgPol(cfgPol), .cfgEdge(cfgEdge),
    .cfgWidth(cfgWidth), .cfgDiv(cfgDiv), .start(start), .txWord(txWord),
    .csEn(csEn), .miso(miso), .sck(sck), .mosi(mosi), .csN(csN),
    .busy(busy), .rxValid(rxValid), .rxWord(rxWord)
  );

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  function automatic int bitsOf(input logic [1:0] sel);
    return (sel == 2'b00) ? 8 : (sel == 2'b01) ? 16 : 32;
  endfunction

  // behavioural reference model, advanced on every rising edge
  bit          mPol, mCke, mBusy, mPhase, mMosi, mValid, mCsN;
  logic [1:0]  mWsel;
  int          mDiv, mTick, mEdgeN, mW;
  logic [31:0] mRx;
  bit          txq[$];
  bit          rxq[$];

  always @(posedge clk) begin
    if (!rstN) begin
      mPol = 0; mCke = 1; mWsel = 2'b00; mDiv = 0; mBusy = 0; mPhase = 0;
      mMosi = 0; mValid = 0; mCsN = 1; mTick = 0; mEdgeN = 0; mW = 8; mRx = '0;
    end else begin
      mValid = 0;
      mCsN = !csEn;
      if (!mBusy) begin
        if (cfgWe) begin
          mPol = cfgPol; mCke = cfgEdge; mWsel = cfgWidth; mDiv = int'(cfgDiv);
        end
        if (start) begin
          mBusy = 1; mTick = 0; mEdgeN = 0; mW = bitsOf(mWsel);
          txq.delete(); rxq.delete();
          for (int i = mW - 1; i >= 0; i--) txq.push_back(txWord[i]);
          mMosi = txq[0];
        end
      end else if (mTick == mDiv) begin
        mTick = 0;
        mPhase = !mPhase;
        if ((mEdgeN % 2) == int'(!mCke)) rxq.push_back(miso);
        else if (mEdgeN != 2 * mW - 1) mMosi = txq[(mEdgeN + 1) / 2];
        if (mEdgeN == 2 * mW - 1) begin
          mBusy = 0; mValid = 1; mRx = '0;
          for (int i = 0; i < mW; i++) mRx[mW - 1 - i] = rxq[i];
        end
        mEdgeN++;
      end else begin
        mTick++;
      end
    end
  end

  always @(negedge clk) begin
    if (compareOn && rstN) begin
      check(sck == (mPol ^ mPhase), "R2 R3 sck level", 32'(sck), 32'(mPol ^ mPhase));
      check(mosi == mMosi, "R4 R5 mosi bit", 32'(mosi), 32'(mMosi));
      check(busy == mBusy, "R8 busy", 32'(busy), 32'(mBusy));
      check(rxValid == mValid, "R8 rxValid", 32'(rxValid), 32'(mValid));
      check(csN == mCsN, "R10 csN", 32'(csN), 32'(mCsN));
      if (mValid) check(rxWord == mRx, "R4 R7 rxWord", rxWord, mRx);
    end
  end

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R8 watchdog actual=still_running expected=finished");
    finishRun();
  end

  task automatic setCfg(input bit pol, input bit cke, input logic [1:0] ws, input int div);
    @(negedge clk);
    cfgWe = 1'b1; cfgPol = pol; cfgEdge = cke; cfgWidth = ws; cfgDiv = 8'(div);
    @(negedge clk);
    cfgWe = 1'b0;
    check(sck == pol, "R3 idle sck after config", 32'(sck), 32'(pol));
  endtask

  task automatic xfer(input logic [31:0] tx, input int w, input int div, input bit disturb,
                      output logic [31:0] rx);
    int cnt;
    int tog;
    logic prev;
    @(negedge clk);
    start = 1'b1; txWord = tx;
    @(negedge clk);
    start = 1'b0;
    cnt = 1; tog = 0; prev = sck;
    while (!rxValid && cnt < 5000) begin
      @(negedge clk);
      if (disturb && cnt == 5) begin
        start = 1'b1; txWord = ~tx; cfgWe = 1'b1; cfgPol = ~cfgPol;
        cfgEdge = ~cfgEdge; cfgWidth = 2'b00; cfgDiv = 8'd0;
      end else begin
        start = 1'b0; cfgWe = 1'b0;
      end
      cnt++;
      if (sck != prev) tog++;
      prev = sck;
    end
    start = 1'b0; cfgWe = 1'b0;
    rx = rxWord;
    check(cnt == 2 * w * (div + 1) + 1, disturb ? "R9 R2 word duration" : "R2 word duration",
          32'(cnt), 32'(2 * w * (div + 1) + 1));
    check(tog == 2 * w, "R6 sck transitions per word", 32'(tog), 32'(2 * w));
  endtask

  initial begin
    logic [31:0] rx;
    logic [31:0] tx;
    repeat (3) @(negedge clk);
    check(sck == 1'b0, "R1 reset sck", 32'(sck), 32'd0);
    check(busy == 1'b0, "R1 reset busy", 32'(busy), 32'd0);
    check(rxValid == 1'b0, "R1 reset rxValid", 32'(rxValid), 32'd0);
    check(csN == 1'b1, "R1 reset csN", 32'(csN), 32'd1);
    check(mosi == 1'b0, "R1 reset mosi", 32'(mosi), 32'd0);
    rstN = 1'b1;
    compareOn = 1'b1;
    @(negedge clk);
    csEn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(csN == 1'b0, "R10 csN asserted", 32'(csN), 32'd0);

    // all modes, all word lengths, several divisors, random miso
    for (int m = 0; m < 4; m++) begin
      for (int ws = 0; ws < 3; ws++) begin
        setCfg(m[1], !m[0], 2'(ws), (m + ws) % 4);
        tx = 32'h9E3779B9 * (m * 3 + ws + 1);
        xfer(tx, bitsOf(2'(ws)), (m + ws) % 4, 1'b0, rx);
      end
    end

    // loopback: returned word equals sent word
    loopMode = 1'b1;
    for (int m = 0; m < 4; m++) begin
      setCfg(m[1], !m[0], 2'(m % 3), m % 2);
      tx = 32'hC3A5_5A3C ^ (32'h1111_1111 * m);
      xfer(tx, bitsOf(2'(m % 3)), m % 2, 1'b0, rx);
      tx = (m % 3 == 0) ? (tx & 32'hFF) : (m % 3 == 1) ? (tx & 32'hFFFF) : tx;
      check(rx == tx, "R11 loopback word", rx, tx);
    end
    loopMode = 1'b0;

    // start and config write in mid-word must not leak in
    setCfg(1'b1, 1'b0, 2'b01, 1);
    xfer(32'h0000_B00F, 16, 1, 1'b1, rx);
    @(negedge clk);
    check(sck == 1'b1, "R9 idle polarity kept", 32'(sck), 32'd1);
    check(busy == 1'b0, "R9 no extra word started", 32'(busy), 32'd0);

    csEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(csN == 1'b1, "R10 csN released", 32'(csN), 32'd1);
    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule